// File: doc/BRIEF.md
# Infrared Receive Pulse Sampler

This block is the receive front end for a consumer infrared remote-control link. The raw detector output passes through a two-flop synchronizer. It is then sampled on a single-cycle tick enable, which a selectable prescaler derives from the module clock. An optional inversion is applied, and a noise filter rejects level changes that do not persist. The filtered signal is cut into runs of constant level, and each run is measured in sample ticks.

Each measured run becomes one or more 8-bit entries in a 64-deep receive queue. A pulse-capture mode decides which levels are stored. A sticky idle flag reports that the line has been quiet for a programmable number of ticks. Software sets the block up through a small write-only register port and drains the queue through a show-ahead read port.

Four write addresses exist:
- 0: control.
- 1: sample setup.
- 2: quiet limit.
- 3: receive options.

Top module: `cir_rx_sampler`

## Requirements
- R1: Sampling and capture run only while control bits [5:4] are both 1. With any other value no entry is written and the run state is held at its reset value.
- R2: Control bits [7:6] select the capture mode: 0 stores nothing (reset value), 1 stores runs of both levels, 2 stores only level-1 runs, 3 stores only level-0 runs.
- R3: Sample-setup bits [1:0] pick the sample tick period: 64, 128, 256 or 512 module-clock cycles for encodings 0, 1, 2, 3.
- R4: Sample-setup bits [7:2] hold a noise threshold N in ticks. A level change is accepted only once the new level has been seen on more than N consecutive ticks. Shorter glitches are absorbed into the running run, and accepted run lengths equal the true lengths.
- R5: An entry carries the run level in bit 7 and the length in ticks in bits [6:0]. A run longer than 127 ticks is emitted as entries of 127 ticks followed by the remainder, all with the same level.
- R6: Bit 0 at address 3 inverts the synchronized input before filtering and measurement.
- R7: The 8-bit quiet limit T at address 2 sets a sticky idle flag after (T+1)*128 ticks with no accepted level change. Any register write clears the flag and restarts the quiet count.
- R8: The queue holds 64 entries. The oldest entry is shown on rd_data, rd_en removes it, and empty and full flags report the queue state.
- R9: An entry offered while the queue is full is dropped and sets a sticky overflow flag. Any register write clears that flag.
- R10: After reset all registers are 0 except the noise threshold, which is 1. The queue is empty, and the overflow and idle flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 control, 1 sample setup, 2 quiet limit, 3 receive options) |
| cfg_wdata | input | 8 | Register write data |
| ir_in | input | 1 | Raw infrared detector level, asynchronous |
| rd_en | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Oldest queue entry: {level, length} |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds 64 entries |
| fifo_ovf | output | 1 | Sticky: an entry was dropped |
| idle_flag | output | 1 | Sticky: quiet time reached |

## Verification
One table of mark and space lengths is replayed under each capture mode, with inversion, and at the divide-by-128 and divide-by-256 tick rates. The results separate mode filtering from level tracking, and a wrong prescaler shows up as scaled lengths. One-tick glitches are fed in at the default threshold and at threshold zero: the first must merge into the surrounding run, and the second must split it into separate entries. Further runs cover the following:
- a 300-tick mark, for entry splitting;
- a long stream of short runs, for queue saturation and overflow clearing;
- a quiet line, checked before and after the idle limit.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam int ENTRY_W = 8;
  localparam int LEN_W   = ENTRY_W - 1;
  localparam int NTHR_W  = 6;
  localparam int QUIET_W = 8;
  localparam int QUIET_SHIFT = 7;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_SAMP  = 2'd1;
  localparam logic [1:0] ADDR_QUIET = 2'd2;
  localparam logic [1:0] ADDR_RXOPT = 2'd3;

  typedef enum logic [1:0] {
    CAP_NONE  = 2'd0,
    CAP_BOTH  = 2'd1,
    CAP_MARK  = 2'd2,
    CAP_SPACE = 2'd3
  } cap_mode_e;

  typedef struct packed {
    logic             lvl;
    logic [LEN_W-1:0] len;
  } run_entry_t;
endpackage

// File: rtl/cir_tick_gen.sv
module cir_tick_gen #(
  parameter int BASE_LOG2 = 6,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = ((CNT_W)'(1) << (BASE_LOG2 + int'(sel))) - (CNT_W)'(1);
    tick  = en && (cnt_q >= limit);
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + (CNT_W)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick on consecutive cycles");
endmodule

// File: rtl/cir_run_meas.sv
module cir_run_meas import cir_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               ir_raw,
  input  logic               invert,
  input  logic [NTHR_W-1:0]  nthr,
  input  logic [QUIET_W-1:0] quiet_lim,
  input  cap_mode_e          cap_mode,
  input  logic               clr_idle,
  output logic               push,
  output run_entry_t         push_data,
  output logic               idle
);
  localparam int CAND_W = NTHR_W + 1;
  localparam int IDLE_W = QUIET_W + QUIET_SHIFT + 1;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic              sync1_q, sync2_q;
  logic              lvl_q, lvl_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [CAND_W-1:0] cand_q, cand_d;
  logic [IDLE_W-1:0] quiet_q, quiet_d, quiet_max;
  logic              idle_q, idle_d;
  logic              samp, differs, accept, split, keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= ir_raw;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    samp      = sync2_q ^ invert;
    differs   = samp != lvl_q;
    accept    = tick && differs && (cand_q >= {1'b0, nthr});
    split     = tick && !accept && (len_q == LEN_MAX);
    quiet_max = ({{(IDLE_W-QUIET_W){1'b0}}, quiet_lim} + (IDLE_W)'(1)) << QUIET_SHIFT;

    unique case (cap_mode)
      CAP_BOTH:  keep = 1'b1;
      CAP_MARK:  keep = lvl_q;
      CAP_SPACE: keep = !lvl_q;
      default:   keep = 1'b0;
    endcase

    push          = en && (accept || split) && keep;
    push_data.lvl = lvl_q;
    push_data.len = len_q;

    lvl_d   = lvl_q;
    len_d   = len_q;
    cand_d  = cand_q;
    quiet_d = quiet_q;
    if (!en) begin
      lvl_d   = 1'b0;
      len_d   = '0;
      cand_d  = '0;
      quiet_d = '0;
    end else if (tick) begin
      if (accept) begin
        lvl_d   = samp;
        len_d   = (LEN_W)'(1);
        cand_d  = '0;
        quiet_d = '0;
      end else begin
        len_d  = split ? (LEN_W)'(1) : len_q + (LEN_W)'(1);
        cand_d = differs ? cand_q + (CAND_W)'(1) : '0;
        if (quiet_q < quiet_max) quiet_d = quiet_q + (IDLE_W)'(1);
      end
    end
    if (clr_idle) quiet_d = '0;

    idle_d = idle_q || (en && (quiet_q >= quiet_max));
    if (clr_idle) idle_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      len_q   <= '0;
      cand_q  <= '0;
      quiet_q <= '0;
      idle_q  <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      len_q   <= len_d;
      cand_q  <= cand_d;
      quiet_q <= quiet_d;
      idle_q  <= idle_d;
    end
  end

  assign idle = idle_q;

  p_level_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (lvl_q != $past(lvl_q))) |-> $past(tick))
    else $error("level changed without a sample tick");

  p_idle_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !clr_idle) |=> idle_q) else $error("idle flag dropped without a write");
endmodule

// File: rtl/cir_fifo.sv
module cir_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         clr_ovf,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wptr_q, wptr_d, rptr_q, rptr_d, fill;
  logic          ovf_q, ovf_d, do_wr, do_rd;

  always_comb begin
    fill   = wptr_q - rptr_q;
    empty  = wptr_q == rptr_q;
    full   = fill == (AW+1)'(DEPTH);
    do_wr  = push && !full;
    do_rd  = pop && !empty;
    wptr_d = do_wr ? wptr_q + (AW+1)'(1) : wptr_q;
    rptr_d = do_rd ? rptr_q + (AW+1)'(1) : rptr_q;
    ovf_d  = clr_ovf ? 1'b0 : (ovf_q || (push && full));
    dout   = mem[rptr_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ovf = ovf_q;

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH)) else $error("queue fill above depth");

  p_pop_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> $stable(rptr_q)) else $error("read pointer moved on empty");

  p_ovf_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr_ovf) |=> ovf_q) else $error("drop did not flag overflow");
endmodule

// File: rtl/cir_rx_sampler.sv
module cir_rx_sampler import cir_pkg::*; #(
  parameter int FIFO_DEPTH    = 64,
  parameter int BASE_DIV_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       ir_in,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       fifo_empty,
  output logic       fifo_full,
  output logic       fifo_ovf,
  output logic       idle_flag
);
  localparam logic [7:0] SAMP_RST = {NTHR_W'(1), 2'b00};

  logic       rs1_q, rs2_q, rst_i;
  logic [3:0] ctrl_q, ctrl_d;
  logic [7:0] samp_q, samp_d;
  logic [7:0] quiet_q, quiet_d;
  logic       inv_q, inv_d;
  logic       en, tick, push;
  run_entry_t push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  always_comb begin
    ctrl_d  = ctrl_q;
    samp_d  = samp_q;
    quiet_d = quiet_q;
    inv_d   = inv_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        ADDR_CTRL:  ctrl_d  = cfg_wdata[7:4];
        ADDR_SAMP:  samp_d  = cfg_wdata;
        ADDR_QUIET: quiet_d = cfg_wdata;
        default:    inv_d   = cfg_wdata[0];
      endcase
    end
    en = ctrl_q[1:0] == 2'b11;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q  <= '0;
      samp_q  <= SAMP_RST;
      quiet_q <= '0;
      inv_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      samp_q  <= samp_d;
      quiet_q <= quiet_d;
      inv_q   <= inv_d;
    end
  end

  cir_tick_gen #(.BASE_LOG2(BASE_DIV_LOG2), .SEL_W(2)) u_tick (
    .clk(clk), .rst_n(rst_i), .en(en), .sel(samp_q[1:0]), .tick(tick)
  );

  cir_run_meas u_meas (
    .clk(clk), .rst_n(rst_i), .en(en), .tick(tick), .ir_raw(ir_in),
    .invert(inv_q), .nthr(samp_q[7:2]), .quiet_lim(quiet_q),
    .cap_mode(cap_mode_e'(ctrl_q[3:2])), .clr_idle(cfg_we),
    .push(push), .push_data(push_data), .idle(idle_flag)
  );

  cir_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(push), .din(push_data), .pop(rd_en),
    .clr_ovf(cfg_we), .dout(rd_data), .empty(fifo_empty), .full(fifo_full),
    .ovf(fifo_ovf)
  );

  p_no_push_disabled_r1: assert property (@(posedge clk) disable iff (!rst_i)
    !en |-> !push) else $error("entry written while receive disabled");
endmodule

// File: tb/cir_rx_sampler_bench.sv
module cir_rx_sampler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT = 6;
  localparam logic [7:0] PAT [NPAT] = '{8'h8A, 8'h14, 8'h85, 8'h1E, 8'h87, 8'h03};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       ir_in;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       fifo_empty, fifo_full, fifo_ovf, idle_flag;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cir_rx_sampler u_cir_rx_sampler (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ir_in(ir_in), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_ovf(fifo_ovf),
    .idle_flag(idle_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rd_en = 1'b0; ir_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic hold(input logic lvl, input int ticks, input int tk);
    ir_in = lvl;
    repeat (ticks * tk) @(negedge clk);
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string req);
    check(!fifo_empty && rd_data == exp, req, {fifo_empty, rd_data}, exp);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pop_skip();
    check(!fifo_empty && !rd_data[7], "R5 first run level", {fifo_empty, rd_data}, 0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic bit kept(input logic [1:0] pm, input logic lvl);
    return (pm == 2'd1) || (pm == 2'd2 && lvl) || (pm == 2'd3 && !lvl);
  endfunction

  // Table walk: same mark/space pattern under a given mode, inversion and divider
  task automatic run_table(input logic [1:0] pm, input logic inv, input logic [1:0] sel,
                           input string req);
    int tk;
    tk = 64 << sel;
    do_reset();
    ir_in = inv;
    wr(2'd1, {6'd1, sel});
    wr(2'd3, {7'd0, inv});
    wr(2'd0, {pm, 2'b11, 4'd0});
    repeat (tk/2 + 8*tk) @(negedge clk);
    for (int i = 0; i < NPAT; i++) hold(PAT[i][7] ^ inv, int'(PAT[i][6:0]), tk);
    if (kept(pm, 1'b0)) pop_skip();
    for (int i = 0; i < NPAT-1; i++)
      if (kept(pm, PAT[i][7])) pop_expect(PAT[i], req);
    check(fifo_empty, {req, " no extra entry"}, fifo_empty, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R10: reset state
    check(fifo_empty && !fifo_full && !fifo_ovf && !idle_flag, "R10 reset flags",
          {fifo_empty, fifo_full, fifo_ovf, idle_flag}, 4'b1000);

    run_table(2'd1, 1'b0, 2'd0, "R2 both levels");
    run_table(2'd2, 1'b0, 2'd0, "R2 mark only");
    run_table(2'd3, 1'b0, 2'd0, "R2 space only");
    run_table(2'd0, 1'b0, 2'd0, "R2 capture none");
    run_table(2'd1, 1'b1, 2'd0, "R6 invert");
    run_table(2'd1, 1'b0, 2'd1, "R3 divide 128");
    run_table(2'd1, 1'b0, 2'd2, "R3 divide 256");

    // R1: enable field not fully set -> nothing stored
    do_reset();
    wr(2'd0, 8'h50);
    for (int i = 0; i < 20; i++) hold(i[0], 3, 64);
    check(fifo_empty, "R1 partial enable", fifo_empty, 1);
    wr(2'd0, 8'h40);
    for (int i = 0; i < 20; i++) hold(i[0], 3, 64);
    check(fifo_empty, "R1 enable off", fifo_empty, 1);

    // R4 + R10: default threshold 1 absorbs a one-tick glitch
    do_reset();
    wr(2'd0, 8'h70);
    repeat (32 + 8*64) @(negedge clk);
    hold(1, 10, 64); hold(0, 9, 64); hold(1, 1, 64); hold(0, 10, 64); hold(1, 4, 64);
    pop_skip();
    pop_expect(8'h8A, "R4 mark before glitch");
    pop_expect(8'h14, "R4 glitch absorbed R10 default threshold");
    check(fifo_empty, "R4 no glitch entry", fifo_empty, 1);

    // R4: threshold 0 passes the same glitch
    do_reset();
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h70);
    repeat (32 + 8*64) @(negedge clk);
    hold(1, 10, 64); hold(0, 9, 64); hold(1, 1, 64); hold(0, 10, 64); hold(1, 4, 64);
    pop_skip();
    pop_expect(8'h8A, "R4 thr0 mark");
    pop_expect(8'h09, "R4 thr0 space split");
    pop_expect(8'h81, "R4 thr0 glitch kept");
    pop_expect(8'h0A, "R4 thr0 space after");

    // R5: 300-tick mark splits into 127 + 127 + 46
    do_reset();
    wr(2'd0, 8'h70);
    repeat (32 + 8*64) @(negedge clk);
    hold(1, 300, 64); hold(0, 5, 64);
    pop_skip();
    pop_expect(8'hFF, "R5 split first");
    pop_expect(8'hFF, "R5 split second");
    pop_expect(8'hAE, "R5 split remainder");

    // R8 / R9: saturate the queue
    do_reset();
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h70);
    repeat (32 + 8*64) @(negedge clk);
    for (int i = 0; i < 80; i++) hold(!i[0], 2, 64);
    check(fifo_full, "R8 full after 64", fifo_full, 1);
    check(fifo_ovf, "R9 overflow set", fifo_ovf, 1);
    wr(2'd2, 8'h00);
    check(!fifo_ovf && fifo_full, "R9 overflow cleared by write", {fifo_ovf, fifo_full}, 2'b01);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (!fifo_empty) begin
        if (n == 1) check(rd_data == 8'h82, "R8 order", rd_data, 8'h82);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        n++;
      end
    end
    check(n == 64, "R8 depth", n, 64);

    // R7: idle after (0+1)*128 quiet ticks, cleared by write
    do_reset();
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h70);
    hold(0, 100, 64);
    check(!idle_flag, "R7 not idle early", idle_flag, 0);
    hold(0, 40, 64);
    check(idle_flag, "R7 idle set", idle_flag, 1);
    wr(2'd3, 8'h00);
    check(!idle_flag, "R7 idle cleared", idle_flag, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule